// File: doc/BRIEF.md
# Core Soft-Reset Sequencer

This block lets software reset a USB controller core without touching the chip reset. Software sets a request bit in a control register. The block then drives a core-reset output for a fixed number of cycles. It reports completion only after that output has dropped and the bus master says it is idle.

A 32-bit identification constant is set by a parameter. Its low half gives the core revision, and that revision picks one of two completion styles:

- **Legacy style** (revision below 0x420a): the request bit drops back to zero by itself once the sequence ends, and software polls for that zero.
- **Handshake style** (revision 0x420a or higher): the request bit stays high and a separate done flag rises. Software then clears both bits with a single write, with the done flag being write-one-to-clear.

The register port is a plain 32-bit read/write port with a combinational read path. The whole sequence takes tens of cycles, which is far inside the ten-thousand-poll limit that software allows before it declares a hang.

Top module: `core_softreset_seq`

## Requirements
- R1: After the hardware reset, the request bit and the done flag are 0 and `core_rst_o` is low. Reading the control register at offset 0x010 then returns bit 31 equal to `bus_idle_i` and zero in every other bit.
- R2: A write to offset 0x010 with bit 0 set, while the request bit is clear, sets the request bit. It also raises `core_rst_o` from the next cycle for exactly RESET_CYCLES cycles.
- R3: Completion happens only on a clock edge where `core_rst_o` is low and `bus_idle_i` is high; until then the register view is held. Completion means the request bit clearing in the legacy style, or the done flag (bit 29) setting in the handshake style.
- R4: In the legacy style (ID_VALUE bits 15:0 below 0x420a):
  - the request bit clears itself on completion;
  - bit 29 always reads 0;
  - writes to bit 29 have no effect.
- R5: In the handshake style (ID_VALUE bits 15:0 at or above 0x420a), completion sets bit 29 to 1 and bit 0 stays at 1.
- R6: In the handshake style:
  - writing 1 to bit 29 clears the done flag, and writing 0 leaves it as it is;
  - writing 0 to bit 0 while no sequence is running clears the request bit;
  - so one write of 0x2000_0000 returns both bits to 0.
- R7: While a sequence is running (reset phase or waiting for idle), writes to bit 0 are ignored and the reset length is unchanged. A write of 1 to bit 0 while the request bit is already set starts no new reset.
- R8: Bit 31 of the control register follows `bus_idle_i` in the same cycle. Bits 1 to 28 and bit 30 read 0 and ignore writes.
- R9: Offset 0x040 reads ID_VALUE, and writes to it change nothing.
- R10: Every other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| reg_wr_i | input | 1 | Write strobe for the register port |
| reg_addr_i | input | ADDR_W | Byte offset of the register accessed |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| bus_idle_i | input | 1 | High when the bus master of the core is idle |
| core_rst_o | output | 1 | Reset to the controller core, active high |

## Verification
The properties assume that `bus_idle_i` and the register port are only sampled on rising clock edges. They also assume that writes arrive as single-cycle strobes; the block itself places no rule on how close together writes may come.

The bench drives every input one time unit after the rising edge, so each write is a clean one-cycle pulse. It holds `bus_idle_i` low across whole reset phases to show that completion waits for it. It also places extra request writes inside a running sequence to show that they neither restart nor stretch the reset.

// File: rtl/srst_pkg.sv
package srst_pkg;

  // Byte offsets decoded by the register port
  localparam int CTL_OFS = 'h010;
  localparam int ID_OFS  = 'h040;

  // Control register bit positions
  localparam int REQ_BIT  = 0;
  localparam int DONE_BIT = 29;
  localparam int IDLE_BIT = 31;

  // First revision that uses the done-flag handshake
  localparam logic [15:0] REV_NEW_MIN = 16'h420a;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_RESET = 2'd1,
    SEQ_WAIT  = 2'd2
  } seq_state_e;

endpackage

// File: rtl/srst_regif.sv
module srst_regif #(
  parameter int          ADDR_W   = 8,
  parameter logic [31:0] ID_VALUE = 32'h4f54420a
) (
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  input  logic              req_i,
  input  logic              done_i,
  input  logic              bus_idle_i,
  output logic              ctl_wr_o,
  output logic              wr_req_o,
  output logic              wr_done_o,
  output logic [31:0]       rdata_o
);
  import srst_pkg::*;

  localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(CTL_OFS);
  localparam logic [ADDR_W-1:0] ID_A  = ADDR_W'(ID_OFS);

  logic        hit_ctl;
  logic        hit_id;
  logic [31:0] ctl_view;
  logic        unused_wbits;

  assign hit_ctl   = (addr_i == CTL_A);
  assign hit_id    = (addr_i == ID_A);
  assign ctl_wr_o  = wr_i & hit_ctl;
  assign wr_req_o  = wdata_i[REQ_BIT];
  assign wr_done_o = wdata_i[DONE_BIT];

  // Undefined write bits are dropped here
  assign unused_wbits = ^{wdata_i[31:30], wdata_i[28:1]};

  always_comb begin
    ctl_view           = '0;
    ctl_view[REQ_BIT]  = req_i;
    ctl_view[DONE_BIT] = done_i;
    ctl_view[IDLE_BIT] = bus_idle_i;
  end

  always_comb begin
    if (hit_ctl)     rdata_o = ctl_view;
    else if (hit_id) rdata_o = ID_VALUE;
    else             rdata_o = '0;
  end

endmodule

// File: rtl/srst_seq.sv
module srst_seq #(
  parameter int RESET_CYCLES = 16,
  parameter bit NEW_STYLE    = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ctl_wr_i,
  input  logic wr_req_i,
  input  logic wr_done_i,
  input  logic bus_idle_i,
  output logic req_o,
  output logic done_o,
  output logic core_rst_o
);
  import srst_pkg::*;

  localparam int               CNT_W    = (RESET_CYCLES > 1) ? $clog2(RESET_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RESET_CYCLES - 1);

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             req_q, req_d;
  logic             rst_q, rst_d;
  logic             start;
  logic             finish;
  logic             upd_en;

  assign start  = ctl_wr_i & wr_req_i & ~req_q & (state_q == SEQ_IDLE);
  assign finish = (state_q == SEQ_WAIT) & bus_idle_i;
  assign upd_en = ctl_wr_i | (state_q != SEQ_IDLE);

  // Next-state logic
  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    req_d   = req_q;
    rst_d   = rst_q;
    case (state_q)
      SEQ_IDLE: begin
        if (start) begin
          state_d = SEQ_RESET;
          cnt_d   = CNT_LOAD;
          req_d   = 1'b1;
          rst_d   = 1'b1;
        end else if (NEW_STYLE && ctl_wr_i && !wr_req_i) begin
          req_d = 1'b0;
        end
      end
      SEQ_RESET: begin
        if (cnt_q == '0) begin
          state_d = SEQ_WAIT;
          rst_d   = 1'b0;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      SEQ_WAIT: begin
        if (finish) begin
          state_d = SEQ_IDLE;
          if (!NEW_STYLE) req_d = 1'b0;
        end
      end
      default: begin
        state_d = SEQ_IDLE;
        rst_d   = 1'b0;
      end
    endcase
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      req_q   <= 1'b0;
      rst_q   <= 1'b0;
    end else if (upd_en) begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      req_q   <= req_d;
      rst_q   <= rst_d;
    end
  end

  assign req_o      = req_q;
  assign core_rst_o = rst_q;

  generate
    if (NEW_STYLE) begin : g_done_flag
      logic done_q, done_d;
      logic done_en;

      assign done_en = finish | (ctl_wr_i & wr_done_i);

      always_comb begin
        done_d = done_q;
        if (finish)                     done_d = 1'b1;
        else if (ctl_wr_i && wr_done_i) done_d = 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       done_q <= 1'b0;
        else if (done_en) done_q <= done_d;
      end

      assign done_o = done_q;
    end else begin : g_self_clear
      logic unused_done_wr;
      assign unused_done_wr = wr_done_i;
      assign done_o         = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/core_softreset_seq.sv
module core_softreset_seq #(
  parameter logic [31:0] ID_VALUE     = 32'h4f54420a,
  parameter int          RESET_CYCLES = 16,
  parameter int          ADDR_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              bus_idle_i,
  output logic              core_rst_o
);
  import srst_pkg::*;

  localparam bit NEW_STYLE = (ID_VALUE[15:0] >= REV_NEW_MIN);

  logic ctl_wr;
  logic wr_req;
  logic wr_done;
  logic req_q;
  logic done_q;

  srst_regif #(
    .ADDR_W  (ADDR_W),
    .ID_VALUE(ID_VALUE)
  ) u_regif (
    .wr_i      (reg_wr_i),
    .addr_i    (reg_addr_i),
    .wdata_i   (reg_wdata_i),
    .req_i     (req_q),
    .done_i    (done_q),
    .bus_idle_i(bus_idle_i),
    .ctl_wr_o  (ctl_wr),
    .wr_req_o  (wr_req),
    .wr_done_o (wr_done),
    .rdata_o   (reg_rdata_o)
  );

  srst_seq #(
    .RESET_CYCLES(RESET_CYCLES),
    .NEW_STYLE   (NEW_STYLE)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl_wr_i  (ctl_wr),
    .wr_req_i  (wr_req),
    .wr_done_i (wr_done),
    .bus_idle_i(bus_idle_i),
    .req_o     (req_q),
    .done_o    (done_q),
    .core_rst_o(core_rst_o)
  );

endmodule

// File: rtl/core_softreset_seq_chk.sv
module core_softreset_seq_chk #(
  parameter int          RESET_CYCLES = 16,
  parameter bit          NEW_STYLE    = 1'b1,
  parameter int          ADDR_W       = 8,
  parameter logic [31:0] ID_VALUE     = 32'h4f54420a
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic              wr_req_bit,
  input logic              wr_done_bit,
  input logic [31:0]       reg_rdata_o,
  input logic              bus_idle_i,
  input logic              core_rst_o,
  input logic              req_q,
  input logic              done_q
);
  localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(srst_pkg::CTL_OFS);
  localparam logic [ADDR_W-1:0] ID_A  = ADDR_W'(srst_pkg::ID_OFS);

  int hi_cnt;

  // Counts the cycles the core reset has been high
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          hi_cnt <= 0;
    else if (core_rst_o) hi_cnt <= hi_cnt + 1;
    else                 hi_cnt <= 0;
  end

  a_r2_start: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_i && reg_addr_i == CTL_A && wr_req_bit && !req_q) |=> core_rst_o);

  a_r2_rst_has_req: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_o |-> req_q);

  a_r2_len_exact: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_rst_o) |-> (hi_cnt == RESET_CYCLES));

  a_r7_len_bound: assert property (@(posedge clk) disable iff (!rst_n)
    core_rst_o |-> (hi_cnt < RESET_CYCLES));

  a_r9_id_const: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i == ID_A) |-> (reg_rdata_o == ID_VALUE));

  generate
    if (NEW_STYLE) begin : g_new
      a_r3_done_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $past(bus_idle_i && !core_rst_o));

      a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> req_q);

      a_r6_done_w1c_only: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(done_q) |-> $past(reg_wr_i && reg_addr_i == CTL_A && wr_done_bit));
    end else begin : g_legacy
      a_r3_clear_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_q) |-> $past(bus_idle_i && !core_rst_o));

      a_r4_no_done: assert property (@(posedge clk) disable iff (!rst_n)
        !done_q);
    end
  endgenerate

endmodule

bind core_softreset_seq core_softreset_seq_chk #(
  .RESET_CYCLES(RESET_CYCLES),
  .NEW_STYLE   (NEW_STYLE),
  .ADDR_W      (ADDR_W),
  .ID_VALUE    (ID_VALUE)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr_i   (reg_wr_i),
  .reg_addr_i (reg_addr_i),
  .wr_req_bit (reg_wdata_i[0]),
  .wr_done_bit(reg_wdata_i[29]),
  .reg_rdata_o(reg_rdata_o),
  .bus_idle_i (bus_idle_i),
  .core_rst_o (core_rst_o),
  .req_q      (req_q),
  .done_q     (done_q)
);

// File: tb/tb_core_softreset_seq.sv
module tb_core_softreset_seq;

  localparam int          RC      = 16;
  localparam logic [31:0] ID_NEW  = 32'h4f54420a;
  localparam logic [31:0] ID_OLD  = 32'h4f54400a;
  localparam logic [7:0]  A_CTL   = 8'h10;
  localparam logic [7:0]  A_ID    = 8'h40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  wr = 2'b00;
  logic [7:0]  addr = A_CTL;
  logic [31:0] wdata = '0;
  logic        bus_idle = 1'b1;
  logic [31:0] rdata [2];
  logic [1:0]  crst;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 0;

  always #2 clk = ~clk;

  // index 0: handshake style, index 1: legacy style
  core_softreset_seq #(.ID_VALUE(ID_NEW), .RESET_CYCLES(RC), .ADDR_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(wr[0]), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata[0]), .bus_idle_i(bus_idle),
    .core_rst_o(crst[0]));

  core_softreset_seq #(.ID_VALUE(ID_OLD), .RESET_CYCLES(RC), .ADDR_W(8)) dut_leg (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(wr[1]), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata[1]), .bus_idle_i(bus_idle),
    .core_rst_o(crst[1]));

  // Behavioural reference model
  int m_req [2];
  int m_done[2];
  int m_left[2];
  int m_wait[2];
  bit started = 0;

  always @(posedge clk) begin
    for (int i = 0; i < 2; i++) begin
      bit hs;
      bit busy;
      bit fin;
      bit wrc;
      int p_req;
      hs    = (i == 0);
      busy  = (m_left[i] > 0) || (m_wait[i] != 0);
      fin   = (m_left[i] == 0) && (m_wait[i] != 0) && bus_idle;
      wrc   = wr[i] && (addr == A_CTL);
      p_req = m_req[i];
      if (!rst_n) begin
        m_req[i] = 0; m_done[i] = 0; m_left[i] = 0; m_wait[i] = 0;
      end else begin
        if (wrc && hs && wdata[29]) m_done[i] = 0;
        if (m_left[i] > 0) begin
          m_left[i] = m_left[i] - 1;
          if (m_left[i] == 0) m_wait[i] = 1;
        end else if (fin) begin
          m_wait[i] = 0;
        end
        if (wrc && !busy) begin
          if (wdata[0] && p_req == 0) begin
            m_req[i] = 1; m_left[i] = RC;
          end else if (hs && !wdata[0]) begin
            m_req[i] = 0;
          end
        end
        if (fin) begin
          if (hs) m_done[i] = 1;
          else    m_req[i]  = 0;
        end
      end
    end
    if (!rst_n) started = 1;
  end

  // Reset-length monitor
  int run_len [2] = '{0, 0};
  int last_len[2] = '{0, 0};

  always @(negedge clk) begin
    for (int i = 0; i < 2; i++) begin
      if (crst[i] === 1'b1) run_len[i]++;
      else if (run_len[i] != 0) begin
        last_len[i] = run_len[i];
        run_len[i]  = 0;
      end
    end
  end

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && started && !done_flag) begin
      for (int i = 0; i < 2; i++) begin
        logic        exp_rst;
        logic [31:0] exp_ctl;
        exp_rst = (m_left[i] > 0);
        n_chk++;
        if (crst[i] !== exp_rst) begin
          n_bad++;
          $display("FAIL R2 model core reset inst%0d act=%b exp=%b", i, crst[i], exp_rst);
        end
        if (addr == A_CTL) begin
          exp_ctl = {bus_idle, 1'b0, (m_done[i] != 0), 28'b0, (m_req[i] != 0)};
          n_chk++;
          if (rdata[i] !== exp_ctl) begin
            n_bad++;
            $display("FAIL R3 model ctl inst%0d act=%h exp=%h", i, rdata[i], exp_ctl);
          end
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr_reg(input logic [1:0] m, input logic [7:0] a, input logic [31:0] d);
    step();
    wr = m; addr = a; wdata = d;
    step();
    wr = 2'b00;
  endtask

  task automatic look(input logic [7:0] a);
    addr = a;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    look(A_CTL);
    chk("R1 ctl hs", rdata[0], 32'h8000_0000);
    chk("R1 ctl legacy", rdata[1], 32'h8000_0000);
    chk("R1 core reset", {30'b0, crst}, 32'h0);

    // R9: identification register, read-only
    look(A_ID);
    chk("R9 id hs", rdata[0], ID_NEW);
    chk("R9 id legacy", rdata[1], ID_OLD);
    wr_reg(2'b11, A_ID, 32'h1234_5678);
    look(A_ID);
    chk("R9 id after write", rdata[0], ID_NEW);

    // R10: unmapped offsets
    look(8'h20);
    chk("R10 unmapped hs", rdata[0], 32'h0);
    chk("R10 unmapped legacy", rdata[1], 32'h0);

    // R8: undefined bits ignore writes, bit 31 is live
    wr_reg(2'b11, A_CTL, 32'h5FFF_FFFE);
    step(); bus_idle = 1'b0;
    look(A_CTL);
    chk("R8 ctl idle low hs", rdata[0], 32'h0);
    chk("R8 ctl idle low legacy", rdata[1], 32'h0);
    step(); bus_idle = 1'b1;
    look(A_CTL);
    chk("R8 ctl idle high", rdata[0], 32'h8000_0000);

    // R2, R7: run with bus not idle; extra writes while running
    step(); bus_idle = 1'b0;
    wr_reg(2'b11, A_CTL, 32'h1);
    repeat (4) step();
    wr_reg(2'b11, A_CTL, 32'h1);
    wr_reg(2'b01, A_CTL, 32'h0);
    repeat (20) step();
    chk("R2 R7 reset length hs", last_len[0], RC);
    chk("R2 R7 reset length legacy", last_len[1], RC);

    // R3: completion waits for bus idle
    look(A_CTL);
    chk("R3 hs waiting", rdata[0], 32'h0000_0001);
    chk("R3 legacy waiting", rdata[1], 32'h0000_0001);
    step(); bus_idle = 1'b1;
    step();
    look(A_CTL);
    chk("R5 hs done set req held", rdata[0], 32'hA000_0001);
    chk("R4 legacy self clear", rdata[1], 32'h8000_0000);

    // R6, R7: done written 0 stays; request already set starts nothing
    wr_reg(2'b01, A_CTL, 32'h0000_0001);
    repeat (3) step();
    look(A_CTL);
    chk("R6 done kept on 0 write", rdata[0], 32'hA000_0001);
    chk("R7 no restart while req set", {31'b0, crst[0]}, 32'h0);
    wr_reg(2'b01, A_CTL, 32'h2000_0000);
    look(A_CTL);
    chk("R6 single write clears both", rdata[0], 32'h8000_0000);

    // R4: legacy ignores bit 29 writes
    wr_reg(2'b10, A_CTL, 32'h2000_0000);
    look(A_CTL);
    chk("R4 legacy bit29 write", rdata[1], 32'h8000_0000);

    // Second run with bus idle throughout
    wr_reg(2'b11, A_CTL, 32'h1);
    repeat (22) step();
    chk("R2 second run length hs", last_len[0], RC);
    chk("R2 second run length legacy", last_len[1], RC);
    look(A_CTL);
    chk("R5 second run hs", rdata[0], 32'hA000_0001);
    chk("R4 second run legacy", rdata[1], 32'h8000_0000);

    // R6: acknowledge again, then a fresh start works
    wr_reg(2'b01, A_CTL, 32'h2000_0000);
    wr_reg(2'b01, A_CTL, 32'h1);
    look(A_CTL);
    chk("R2 restart after ack", {31'b0, crst[0]}, 32'h1);
    repeat (22) step();
    look(A_CTL);
    chk("R5 third run hs", rdata[0], 32'hA000_0001);

    repeat (2) step();
    finish_run();
  end

endmodule